// File: doc/BRIEF.md
# Pin Bank Data Port with Atomic Bit Updates

This block is the data half of a 32-pin general-purpose I/O bank. It keeps an output latch that drives the pad outputs and a direction register that drives the pad output enables. It also samples the pad inputs into a register that software can read. All of this sits behind a small register port that completes each access in one cycle. A write takes effect at the clock edge on which it is presented. A read returns data combinationally from the address.

Software can load the whole output latch in one write. It can also change chosen bits without a read-modify-write, using three write-only mask registers. One mask forces bits high, one forces bits low and one inverts bits. In each mask a 1 acts on that bit and a 0 leaves it alone. The direction register is a plain read/write register. Pad muxing, pulls, drive strength and interrupt detection are handled by other blocks.

Top module: `pinbank_io`

## Requirements
- R1: While reset is asserted and after it is released, the output latch and the direction register are all zeros, so padOut and padOe are zero and every pin starts as an input.
- R2: A write to word offset 0x00 loads all output latch bits from busWrData. padOut shows the new value from the clock edge that takes the write.
- R3: A write to offset 0x04 sets to 1 each latch bit whose busWrData bit is 1. Every other latch bit keeps its value.
- R4: A write to offset 0x08 clears to 0 each latch bit whose busWrData bit is 1. Every other latch bit keeps its value.
- R5: A write to offset 0x0C inverts each latch bit whose busWrData bit is 1. Every other latch bit keeps its value.
- R6: A read of offset 0x04, 0x08 or 0x0C returns zero.
- R7: Offset 0x14 is the direction register and can be read and written. A 1 in bit n makes pin n an output, and padOe equals this register.
- R8: A read of offset 0x10 returns the pad inputs after a two-flop synchronizer. A change on padIn is visible two clock edges later and not after only one.
- R9: A read of offset 0x00 returns the current output latch, which equals padOut.
- R10: A write to offset 0x10 changes no state. A write to an unmapped or misaligned address also changes no state. Such addresses read as zero.
- R11: When busWrEn is low, neither the latch nor the direction register changes, whatever the address and data are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busAddr | input | 8 | Byte address of the register |
| busWrEn | input | 1 | Write strobe, sampled at the rising edge |
| busWrData | input | 32 | Write data or bit mask |
| busRdData | output | 32 | Read data for busAddr (combinational) |
| padIn | input | 32 | Pad input levels (asynchronous) |
| padOut | output | 32 | Pad output values (the output latch) |
| padOe | output | 32 | Pad output enables (the direction register) |

## Verification
Any wrong latch or direction state shows on padOut or padOe right after the edge that takes the write. The bench compares both ports against a model after every write, so a wrong bit is seen within one cycle. A mask register that touches bits where the mask is 0 leaves a wrong bit in the latch. Random masks over many writes expose that, and so does a read of offset 0x00. A synchronizer with the wrong depth shows up as a value on offset 0x10 that is early or late by one edge. The bench probes both edges after each input change to catch it.

// File: rtl/pinbank_pkg.sv
package pinbank_pkg;

  // Word indices (byte address >> 2) of the register map
  localparam logic [5:0] WIDX_OUT = 6'd0;
  localparam logic [5:0] WIDX_SET = 6'd1;
  localparam logic [5:0] WIDX_CLR = 6'd2;
  localparam logic [5:0] WIDX_TOG = 6'd3;
  localparam logic [5:0] WIDX_IN  = 6'd4;
  localparam logic [5:0] WIDX_DIR = 6'd5;

  // Write strobes handed from control to datapath, at most one high
  typedef struct packed {
    logic ldOut;
    logic setOut;
    logic clrOut;
    logic togOut;
    logic ldDir;
  } wrStrobe_t;

  // Read-data source select
  typedef enum logic [1:0] {
    RD_ZERO = 2'd0,
    RD_OUT  = 2'd1,
    RD_IN   = 2'd2,
    RD_DIR  = 2'd3
  } rdSel_e;

endpackage

// File: rtl/pinbank_ctrl.sv
module pinbank_ctrl
  import pinbank_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  output wrStrobe_t         strobe,
  output rdSel_e            rdSel
);

  localparam int IDX_W = ADDR_W - 2;

  logic             aligned;
  logic [IDX_W-1:0] wordIdx;

  assign aligned = (busAddr[1:0] == 2'b00);
  assign wordIdx = busAddr[ADDR_W-1:2];

  function automatic logic hit(input logic [IDX_W-1:0] idx, input logic [5:0] ref6);
    return aligned && (idx == IDX_W'(ref6));
  endfunction

  always_comb begin
    strobe        = '0;
    strobe.ldOut  = busWrEn && hit(wordIdx, WIDX_OUT);
    strobe.setOut = busWrEn && hit(wordIdx, WIDX_SET);
    strobe.clrOut = busWrEn && hit(wordIdx, WIDX_CLR);
    strobe.togOut = busWrEn && hit(wordIdx, WIDX_TOG);
    strobe.ldDir  = busWrEn && hit(wordIdx, WIDX_DIR);
  end

  always_comb begin
    rdSel = RD_ZERO;
    if (hit(wordIdx, WIDX_OUT))      rdSel = RD_OUT;
    else if (hit(wordIdx, WIDX_IN))  rdSel = RD_IN;
    else if (hit(wordIdx, WIDX_DIR)) rdSel = RD_DIR;
  end

endmodule

// File: rtl/pinbank_datapath.sv
module pinbank_datapath
  import pinbank_pkg::*;
#(
  parameter int PIN_COUNT   = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  wrStrobe_t            strobe,
  input  rdSel_e               rdSel,
  input  logic [PIN_COUNT-1:0] wrData,
  input  logic [PIN_COUNT-1:0] padIn,
  output logic [PIN_COUNT-1:0] rdData,
  output logic [PIN_COUNT-1:0] padOut,
  output logic [PIN_COUNT-1:0] padOe
);

  logic [PIN_COUNT-1:0] outQ, outD;
  logic [PIN_COUNT-1:0] dirQ;
  logic [PIN_COUNT-1:0] syncQ [SYNC_STAGES];

  // Per-pin next-state of the output latch
  for (genvar p = 0; p < PIN_COUNT; p++) begin : g_pin
    always_comb begin
      outD[p] = outQ[p];
      if (strobe.ldOut)                    outD[p] = wrData[p];
      else if (strobe.setOut && wrData[p]) outD[p] = 1'b1;
      else if (strobe.clrOut && wrData[p]) outD[p] = 1'b0;
      else if (strobe.togOut && wrData[p]) outD[p] = ~outQ[p];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outQ <= '0;
      dirQ <= '0;
    end else begin
      outQ <= outD;
      if (strobe.ldDir) dirQ <= wrData;
    end
  end

  // Input synchronizer chain
  for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_sync
    if (s == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (!rstN) syncQ[s] <= '0;
        else       syncQ[s] <= padIn;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (!rstN) syncQ[s] <= '0;
        else       syncQ[s] <= syncQ[s-1];
      end
    end
  end

  always_comb begin
    unique case (rdSel)
      RD_OUT:  rdData = outQ;
      RD_IN:   rdData = syncQ[SYNC_STAGES-1];
      RD_DIR:  rdData = dirQ;
      default: rdData = '0;
    endcase
  end

  assign padOut = outQ;
  assign padOe  = dirQ;

endmodule

// File: rtl/pinbank_io.sv
module pinbank_io
  import pinbank_pkg::*;
#(
  parameter int ADDR_W      = 8,
  parameter int PIN_COUNT   = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [ADDR_W-1:0]    busAddr,
  input  logic                 busWrEn,
  input  logic [PIN_COUNT-1:0] busWrData,
  output logic [PIN_COUNT-1:0] busRdData,
  input  logic [PIN_COUNT-1:0] padIn,
  output logic [PIN_COUNT-1:0] padOut,
  output logic [PIN_COUNT-1:0] padOe
);

  wrStrobe_t strobe;
  rdSel_e    rdSel;

  pinbank_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .busAddr (busAddr),
    .busWrEn (busWrEn),
    .strobe  (strobe),
    .rdSel   (rdSel)
  );

  pinbank_datapath #(.PIN_COUNT(PIN_COUNT), .SYNC_STAGES(SYNC_STAGES)) u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .strobe (strobe),
    .rdSel  (rdSel),
    .wrData (busWrData),
    .padIn  (padIn),
    .rdData (busRdData),
    .padOut (padOut),
    .padOe  (padOe)
  );

endmodule

// File: rtl/pinbank_checker.sv
module pinbank_checker #(
  parameter int ADDR_W    = 8,
  parameter int PIN_COUNT = 32
) (
  input logic                 clk,
  input logic                 rstN,
  input logic [ADDR_W-1:0]    busAddr,
  input logic                 busWrEn,
  input logic [PIN_COUNT-1:0] busWrData,
  input logic [PIN_COUNT-1:0] busRdData,
  input logic [PIN_COUNT-1:0] padOut,
  input logic [PIN_COUNT-1:0] padOe
);

  logic atOut, atSet, atClr, atTog, atDir;
  assign atOut = (busAddr == ADDR_W'(8'h00));
  assign atSet = (busAddr == ADDR_W'(8'h04));
  assign atClr = (busAddr == ADDR_W'(8'h08));
  assign atTog = (busAddr == ADDR_W'(8'h0C));
  assign atDir = (busAddr == ADDR_W'(8'h14));

  a_r1_reset_clear: assert property (@(posedge clk)
    !rstN |=> (padOut == '0) && (padOe == '0));

  a_r2_load: assert property (@(posedge clk) disable iff (!rstN)
    busWrEn && atOut |=> padOut == $past(busWrData));

  a_r3_set: assert property (@(posedge clk) disable iff (!rstN)
    busWrEn && atSet |=> padOut == ($past(padOut) | $past(busWrData)));

  a_r4_clear: assert property (@(posedge clk) disable iff (!rstN)
    busWrEn && atClr |=> padOut == ($past(padOut) & ~$past(busWrData)));

  a_r5_toggle: assert property (@(posedge clk) disable iff (!rstN)
    busWrEn && atTog |=> padOut == ($past(padOut) ^ $past(busWrData)));

  a_r6_mask_reads_zero: assert property (@(posedge clk) disable iff (!rstN)
    (atSet || atClr || atTog) |-> busRdData == '0);

  a_r7_dir_load: assert property (@(posedge clk) disable iff (!rstN)
    busWrEn && atDir |=> padOe == $past(busWrData));

  a_r9_out_readback: assert property (@(posedge clk) disable iff (!rstN)
    atOut |-> busRdData == padOut);

  a_r11_idle_hold: assert property (@(posedge clk) disable iff (!rstN)
    !busWrEn |=> $stable(padOut) && $stable(padOe));

endmodule

bind pinbank_io pinbank_checker #(.ADDR_W(ADDR_W), .PIN_COUNT(PIN_COUNT)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .busAddr   (busAddr),
  .busWrEn   (busWrEn),
  .busWrData (busWrData),
  .busRdData (busRdData),
  .padOut    (padOut),
  .padOe     (padOe)
);

// File: tb/pinbank_io_bench.sv
module pinbank_io_bench;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [7:0]  busAddr = '0;
  logic        busWrEn = 1'b0;
  logic [31:0] busWrData = '0;
  logic [31:0] busRdData;
  logic [31:0] padIn = '0;
  logic [31:0] padOut, padOe;

  int total = 0;
  int fails = 0;
  bit done = 0;

  logic [31:0] expOut = '0;
  logic [31:0] expDir = '0;

  always #10 clk = ~clk;

  pinbank_io u_pinbank_io (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrEn(busWrEn),
    .busWrData(busWrData), .busRdData(busRdData), .padIn(padIn),
    .padOut(padOut), .padOe(padOe)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Model of the latch after a write
  function automatic logic [31:0] modelOut(input logic [7:0] a, input logic [31:0] d,
                                           input logic [31:0] cur);
    case (a)
      8'h00:   return d;
      8'h04:   return cur | d;
      8'h08:   return cur & ~d;
      8'h0C:   return cur ^ d;
      default: return cur;
    endcase
  endfunction

  function automatic logic [31:0] modelRead(input logic [7:0] a);
    case (a)
      8'h00:   return expOut;
      8'h14:   return expDir;
      default: return 32'h0;
    endcase
  endfunction

  task automatic wr(input logic [7:0] a, input logic [31:0] d, input bit en);
    @(negedge clk);
    busAddr = a; busWrData = d; busWrEn = en;
    @(negedge clk);
    busWrEn = 1'b0;
    if (en) begin
      expOut = modelOut(a, d, expOut);
      if (a == 8'h14) expDir = d;
    end
    #2;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] v);
    @(negedge clk);
    busAddr = a; busWrEn = 1'b0;
    #2 v = busRdData;
  endtask

  task automatic checkPads(input string tagOut, input string tagOe);
    check(tagOut, padOut, expOut);
    check(tagOe, padOe, expDir);
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      total++; fails++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    logic [31:0] oldIn;
    void'($urandom(32'h1234_5678));
    repeat (3) @(posedge clk);
    // R1: reset state while in reset and after release
    @(negedge clk);
    check("R1 padOut in reset", padOut, 32'h0);
    check("R1 padOe in reset", padOe, 32'h0);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 padOut after reset", padOut, 32'h0);
    check("R1 padOe after reset", padOe, 32'h0);
    rd(8'h14, v); check("R1 dir reads zero", v, 32'h0);

    // Directed corners
    wr(8'h00, 32'hA5A5_0F0F, 1'b1); checkPads("R2 load", "R2 oe");
    rd(8'h00, v); check("R9 readback", v, 32'hA5A5_0F0F);
    wr(8'h04, 32'h0000_0000, 1'b1); checkPads("R3 zero mask", "R3 oe");
    wr(8'h04, 32'hFFFF_FFFF, 1'b1); checkPads("R3 all ones", "R3 oe");
    wr(8'h08, 32'h8000_0001, 1'b1); checkPads("R4 edge bits", "R4 oe");
    wr(8'h0C, 32'hFFFF_FFFF, 1'b1); checkPads("R5 invert all", "R5 oe");
    wr(8'h0C, 32'h0000_0000, 1'b1); checkPads("R5 zero mask", "R5 oe");
    wr(8'h14, 32'hDEAD_BEEF, 1'b1); checkPads("R7 out", "R7 dir load");
    rd(8'h14, v); check("R7 dir readback", v, 32'hDEAD_BEEF);
    wr(8'h10, 32'h1357_9BDF, 1'b1); checkPads("R10 input write out", "R10 input write oe");
    wr(8'h18, 32'hFFFF_FFFF, 1'b1); checkPads("R10 unmapped out", "R10 unmapped oe");
    wr(8'h01, 32'h1111_1111, 1'b1); checkPads("R10 misaligned out", "R10 misaligned oe");
    rd(8'h18, v); check("R10 unmapped reads zero", v, 32'h0);
    wr(8'h00, 32'h0, 1'b0); checkPads("R11 no strobe out", "R11 no strobe oe");
    wr(8'h14, 32'h0, 1'b0); checkPads("R11 no strobe dir out", "R11 no strobe dir oe");
    rd(8'h04, v); check("R6 set reads zero", v, 32'h0);
    rd(8'h08, v); check("R6 clear reads zero", v, 32'h0);
    rd(8'h0C, v); check("R6 toggle reads zero", v, 32'h0);

    // R8: synchronizer lag, settle first
    repeat (3) @(negedge clk);
    for (int k = 0; k < 6; k++) begin
      oldIn = padIn;
      @(negedge clk);
      padIn = (k == 0) ? 32'hFFFF_FFFF : $urandom;
      busAddr = 8'h10; busWrEn = 1'b0;
      @(negedge clk); #2 check("R8 one edge old", busRdData, oldIn);
      @(negedge clk); #2 check("R8 two edges new", busRdData, padIn);
    end

    // Random mix
    for (int i = 0; i < 400; i++) begin
      logic [7:0] a;
      logic [31:0] d;
      bit en;
      a  = 8'(($urandom % 8) * 4);
      d  = $urandom;
      en = ($urandom % 8) != 0;
      wr(a, d, en);
      case (a)
        8'h00: checkPads("R2 rand", "R2 rand oe");
        8'h04: checkPads("R3 rand", "R3 rand oe");
        8'h08: checkPads("R4 rand", "R4 rand oe");
        8'h0C: checkPads("R5 rand", "R5 rand oe");
        8'h14: checkPads("R7 rand out", "R7 rand");
        default: checkPads("R10 rand out", "R10 rand oe");
      endcase
      if (i % 5 == 0) begin
        logic [7:0] ra;
        ra = 8'(($urandom % 8) * 4);
        if (ra != 8'h10) begin
          rd(ra, v);
          check("R6 R7 R9 R10 rand read", v, modelRead(ra));
        end
      end
    end

    done = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

endmodule